// File: doc/BRIEF.md
# Receive Packet Status Tracker

This block keeps the host's view of packets sitting in a receive data FIFO. The receiving MAC reports each packet as a start strobe, one strobe per byte written, and an end strobe that carries a 4-bit error type. The tracker counts the bytes of the packet in progress. When the packet ends, it queues a 16-bit status word for it, and it can hold up to DEPTH (default eight) words. The oldest word is always shown on `head_status`.

The host reads the head packet byte by byte and drops it with a discard command. Reading past the received length is a fatal condition. It sets a sticky underrun flag and pulses an adapter-failure event, and only an RX reset or the global reset clears it. Two conditions refuse new packets, and both clear on their own:

- The status queue is full (status overrun).
- The data FIFO level has reached its capacity (RX overrun).

A refused packet is dropped whole and leaves no trace in the queue. Every pin is a plain one-cycle strobe or level. There is no valid/ready back-pressure: the MAC is never stalled, so refusal takes the form of dropping a packet, and the host is never stalled either, so an over-read is flagged instead of held off.

Top module: `rx_pkt_status_tracker`

## Requirements
- R1: After reset, `head_status` reads 16'h8000. `st_receiving`, `st_underrun`, `st_stat_ovr` and `st_rx_ovr` are 0, and no event output is high.
- R2: While the queue is not empty, `head_status` is {1'b0, code[3:0], len[10:0]} for the oldest queued packet. Bit 15 is 0, bits 14..11 are the normalized error type (bit 14 set means an error), and bits 10..0 are the byte count.
- R3: The error type on `mac_err` is stored unchanged when it is 4'b1000 (overrun), 4'b1001 (oversize), 4'b1011 (runt), 4'b1100 (alignment), 4'b1101 (CRC) or 4'b0010 (dribble). Every other value is stored as 4'b0000.
- R4: While the queue is empty, `head_status` is {1'b1, 4'b0000, n}. Here n is the byte count of the packet in progress, or 0 when no packet is in progress.
- R5: Packets leave in arrival order. `cmd_discard` removes the head word. A discard on an empty queue has no effect.
- R6: `st_stat_ovr` is 1 exactly while DEPTH words are queued. A start strobe seen while it is 1 is refused: that packet is not queued and gives no RX-complete event. The flag clears once one word is removed.
- R7: `st_rx_ovr` is set one cycle after `fifo_level` >= FIFO_CAP. It clears one cycle after `fifo_level` <= FIFO_CAP-CLR_MARGIN, and between the two thresholds it holds. A start strobe seen while it is 1 is refused.
- R8: `st_receiving` is 1 from the cycle after an accepted start strobe until the edge that takes the end strobe.
- R9: A `host_rd` strobe is an over-read when the queue is empty or the head packet's bytes are already all read. An over-read sets sticky `st_underrun`, and `evt_adapter_fail` pulses for one cycle only on the read that sets the flag. The flag survives discards and clears only on `cmd_rx_reset` or `rst_n`.
- R10: `evt_rx_complete` pulses for one cycle after the edge that takes the end strobe of an accepted packet.
- R11: `evt_rx_early` pulses once per packet, on the byte that brings the count up to `early_thresh`. A threshold of 0, or one that is never reached, gives no pulse.
- R12: The byte count saturates at 2047.
- R13: `cmd_rx_reset` empties the queue, aborts any packet in progress and clears `st_underrun`. It leaves `st_rx_ovr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| mac_start | input | 1 | Start of a packet from the MAC |
| mac_byte | input | 1 | One byte of the packet in progress was written into the FIFO |
| mac_end | input | 1 | End of the packet in progress |
| mac_err | input | 4 | Error type that comes with `mac_end` |
| fifo_level | input | LVL_W | Current fill level of the data FIFO |
| early_thresh | input | 11 | Byte count at which the early event fires |
| host_rd | input | 1 | Host reads one byte of the head packet |
| cmd_discard | input | 1 | Drop the head packet |
| cmd_rx_reset | input | 1 | Receive-side reset |
| head_status | output | 16 | Status word of the head packet |
| st_receiving | output | 1 | A packet is being written |
| st_underrun | output | 1 | Sticky over-read flag |
| st_stat_ovr | output | 1 | Status queue full |
| st_rx_ovr | output | 1 | Data FIFO full (with hysteresis) |
| evt_rx_complete | output | 1 | One-cycle pulse when an accepted packet ends |
| evt_rx_early | output | 1 | One-cycle pulse when the early threshold is reached |
| evt_adapter_fail | output | 1 | One-cycle pulse when the underrun flag sets |

## Verification
The hardest states to reach are the full queue with a packet arriving and the refusal that packet must meet. The bench gets there by queuing exactly DEPTH packets of distinct lengths. It then offers one more packet and confirms that no completion event appears and that the head word does not change. After a single discard, it checks that a new packet is accepted again and that the whole queue drains in order. The sticky over-read is driven both on a queued packet and on an empty queue, and the bench confirms that a discard does not clear the flag but an RX reset does. Around this, all sixteen error types and a full up-and-down sweep of the FIFO level are checked against values the bench computes itself.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

  localparam int unsigned LEN_W  = 11;
  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_NONE    = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_DRIBBLE = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_OVERRUN = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_OVRSIZE = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_RUNT    = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_ALIGN   = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_CRC     = 4'b1101;

  typedef struct packed {
    logic              incomplete;
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
  } rx_stat_t;

  function automatic logic [CODE_W-1:0] norm_code(input logic [CODE_W-1:0] c);
    case (c)
      CODE_DRIBBLE, CODE_OVERRUN, CODE_OVRSIZE,
      CODE_RUNT, CODE_ALIGN, CODE_CRC: return c;
      default:                         return CODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rxst_queue.sv
module rxst_queue import rxst_pkg::*; #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  rx_stat_t         push_word,
  input  logic             pop,
  output rx_stat_t         head_word,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  rx_stat_t         slots [DEPTH];
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_stat_t slot_q;
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == PTR_W'(i))) slot_q <= push_word;
    end
    assign slots[i] = slot_q;
  end

  assign head_word = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxst_ingress.sv
module rxst_ingress import rxst_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mac_start,
  input  logic              mac_byte,
  input  logic              mac_end,
  input  logic [CODE_W-1:0] mac_err,
  input  logic              refuse,
  input  logic [LEN_W-1:0]  early_thresh,
  output logic              receiving,
  output logic [LEN_W-1:0]  cur_len,
  output logic              push,
  output rx_stat_t          push_word,
  output logic              complete_p,
  output logic              early_p
);

  logic             byte_ok;
  logic [LEN_W-1:0] len_next;

  // Count a byte only inside an accepted packet, and hold at the top of the range.
  assign byte_ok  = receiving && mac_byte && (cur_len != '1);
  assign len_next = byte_ok ? cur_len + LEN_W'(1) : cur_len;

  assign push = receiving && mac_end && !clr;
  always_comb begin
    push_word            = '0;
    push_word.incomplete = 1'b0;
    push_word.code       = norm_code(mac_err);
    push_word.len        = len_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      receiving  <= 1'b0;
      cur_len    <= '0;
      complete_p <= 1'b0;
      early_p    <= 1'b0;
    end else if (clr) begin
      receiving  <= 1'b0;
      cur_len    <= '0;
      complete_p <= 1'b0;
      early_p    <= 1'b0;
    end else begin
      complete_p <= push;
      early_p    <= byte_ok && (len_next == early_thresh);
      if (receiving) begin
        cur_len <= len_next;
        if (mac_end) receiving <= 1'b0;
      end else if (mac_start && !refuse) begin
        receiving <= 1'b1;
        cur_len   <= '0;
      end
    end
  end

endmodule

// File: rtl/rxst_rdtrack.sv
module rxst_rdtrack import rxst_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             host_rd,
  input  logic             pop,
  input  logic             q_empty,
  input  logic [LEN_W-1:0] head_len,
  output logic             underrun,
  output logic             fail_p
);

  logic [LEN_W-1:0] rd_cnt;
  logic             overread;

  assign overread = host_rd && (q_empty || (rd_cnt >= head_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      underrun <= 1'b0;
      fail_p   <= 1'b0;
    end else if (clr) begin
      rd_cnt   <= '0;
      underrun <= 1'b0;
      fail_p   <= 1'b0;
    end else begin
      fail_p <= overread && !underrun;
      if (overread) underrun <= 1'b1;
      if (pop)                        rd_cnt <= '0;
      else if (host_rd && !overread)  rd_cnt <= rd_cnt + LEN_W'(1);
    end
  end

endmodule

// File: rtl/rxst_ovr_mon.sv
module rxst_ovr_mon #(
  parameter int unsigned LVL_W      = 8,
  parameter int unsigned FIFO_CAP   = 200,
  parameter int unsigned CLR_MARGIN = 4,
  localparam int unsigned LOW_MARK  = FIFO_CAP - CLR_MARGIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             rx_ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                rx_ovr <= 1'b0;
    else if (fifo_level >= LVL_W'(FIFO_CAP))   rx_ovr <= 1'b1;
    else if (fifo_level <= LVL_W'(LOW_MARK))   rx_ovr <= 1'b0;
  end

endmodule

// File: rtl/rx_pkt_status_tracker.sv
module rx_pkt_status_tracker import rxst_pkg::*; #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LVL_W      = 8,
  parameter int unsigned FIFO_CAP   = 200,
  parameter int unsigned CLR_MARGIN = 4,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_start,
  input  logic              mac_byte,
  input  logic              mac_end,
  input  logic [3:0]        mac_err,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [10:0]       early_thresh,
  input  logic              host_rd,
  input  logic              cmd_discard,
  input  logic              cmd_rx_reset,
  output logic [15:0]       head_status,
  output logic              st_receiving,
  output logic              st_underrun,
  output logic              st_stat_ovr,
  output logic              st_rx_ovr,
  output logic              evt_rx_complete,
  output logic              evt_rx_early,
  output logic              evt_adapter_fail
);

  logic             q_push, q_pop, q_empty, q_full, refuse;
  rx_stat_t         push_word, head_word;
  logic [CNT_W-1:0] q_count;
  logic [LEN_W-1:0] cur_len;

  assign q_pop  = cmd_discard && !cmd_rx_reset;
  assign refuse = q_full || st_rx_ovr;

  rxst_ovr_mon #(
    .LVL_W(LVL_W), .FIFO_CAP(FIFO_CAP), .CLR_MARGIN(CLR_MARGIN)
  ) u_ovr (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .rx_ovr(st_rx_ovr)
  );

  rxst_ingress u_in (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rx_reset),
    .mac_start(mac_start), .mac_byte(mac_byte), .mac_end(mac_end),
    .mac_err(mac_err), .refuse(refuse), .early_thresh(early_thresh),
    .receiving(st_receiving), .cur_len(cur_len),
    .push(q_push), .push_word(push_word),
    .complete_p(evt_rx_complete), .early_p(evt_rx_early)
  );

  rxst_queue #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rx_reset),
    .push(q_push), .push_word(push_word), .pop(q_pop),
    .head_word(head_word), .count(q_count),
    .empty(q_empty), .full(q_full)
  );

  rxst_rdtrack u_rd (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rx_reset),
    .host_rd(host_rd), .pop(q_pop && !q_empty), .q_empty(q_empty),
    .head_len(head_word.len),
    .underrun(st_underrun), .fail_p(evt_adapter_fail)
  );

  assign st_stat_ovr = q_full;

  // An empty queue shows the running count of the packet in progress.
  assign head_status = q_empty ? {1'b1, 4'b0000, (st_receiving ? cur_len : '0)}
                               : head_word;

endmodule

// File: rtl/rxst_chk.sv
module rxst_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_rx_reset,
  input logic [CNT_W-1:0] q_count,
  input logic [15:0]      head_status,
  input logic             st_receiving,
  input logic             st_underrun,
  input logic             st_stat_ovr,
  input logic             st_rx_ovr,
  input logic             evt_rx_complete,
  input logic             evt_adapter_fail
);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  // R4
  empty_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_status[15] == (q_count == '0));

  // R7
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_receiving) |-> (!$past(st_stat_ovr) && !$past(st_rx_ovr)));

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_underrun && !cmd_rx_reset) |=> st_underrun);

  // R9
  fail_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_underrun) |-> evt_adapter_fail);

  // R10
  complete_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_complete |-> $fell(st_receiving));

endmodule

bind rx_pkt_status_tracker rxst_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_rx_reset(cmd_rx_reset), .q_count(q_count),
  .head_status(head_status), .st_receiving(st_receiving),
  .st_underrun(st_underrun), .st_stat_ovr(st_stat_ovr), .st_rx_ovr(st_rx_ovr),
  .evt_rx_complete(evt_rx_complete), .evt_adapter_fail(evt_adapter_fail)
);

// File: tb/tb_rx_pkt_status_tracker.sv
module tb_rx_pkt_status_tracker;

  localparam int DEPTH = 8, LVL_W = 8, CAP = 200, MARGIN = 4;

  logic clk = 0, rst_n = 0;
  logic mac_start = 0, mac_byte = 0, mac_end = 0;
  logic [3:0] mac_err = 0;
  logic [LVL_W-1:0] fifo_level = 0;
  logic [10:0] early_thresh = 0;
  logic host_rd = 0, cmd_discard = 0, cmd_rx_reset = 0;
  logic [15:0] head_status;
  logic st_receiving, st_underrun, st_stat_ovr, st_rx_ovr;
  logic evt_rx_complete, evt_rx_early, evt_adapter_fail;

  int checks = 0, errors = 0, n_early = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_pkt_status_tracker #(.DEPTH(DEPTH), .LVL_W(LVL_W), .FIFO_CAP(CAP),
                          .CLR_MARGIN(MARGIN)) dut (.*);

  always @(posedge clk) if (rst_n && evt_rx_early) n_early++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  function automatic logic [3:0] exp_code(input int c);
    if (c == 8 || c == 9 || c == 11 || c == 12 || c == 13 || c == 2) return 4'(c);
    return 4'b0000;
  endfunction

  task automatic send_pkt(input int len, input logic [3:0] code);
    mac_start = 1; step(); mac_start = 0;
    mac_byte = 1; repeat (len) step(); mac_byte = 0;
    mac_end = 1; mac_err = code; step(); mac_end = 0; mac_err = 0;
  endtask

  task automatic discard(); cmd_discard = 1; step(); cmd_discard = 0; endtask
  task automatic rx_rst(); cmd_rx_reset = 1; step(); cmd_rx_reset = 0; endtask
  task automatic rd1(); host_rd = 1; step(); host_rd = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    chk("R1 head", 32'(head_status), 32'h8000);
    chk("R1 flags", {28'd0, st_receiving, st_underrun, st_stat_ovr, st_rx_ovr}, 0);
    chk("R1 events", {29'd0, evt_rx_complete, evt_rx_early, evt_adapter_fail}, 0);

    // R2 R3: every error type, distinct lengths
    for (int c = 0; c < 16; c++) begin
      int len = c * 37 + 1;
      send_pkt(len, 4'(c));
      chk("R10 complete pulse", 32'(evt_rx_complete), 1);
      chk("R2 R3 word", 32'(head_status), 32'({1'b0, exp_code(c), 11'(len)}));
      discard();
      chk("R5 discard empties", 32'(head_status), 32'h8000);
    end

    // R4 R8: in-progress count shown while queue empty
    mac_start = 1; step(); mac_start = 0;
    chk("R8 receiving set", 32'(st_receiving), 1);
    mac_byte = 1; repeat (5) step(); mac_byte = 0;
    chk("R4 in-progress", 32'(head_status), 32'h8005);
    mac_end = 1; step(); mac_end = 0;
    chk("R8 receiving clear", 32'(st_receiving), 0);
    discard();
    discard();
    chk("R5 discard on empty", 32'(head_status), 32'h8000);

    // R6: fill the queue, refuse one more, reopen
    for (int i = 0; i < DEPTH; i++) send_pkt(10 + i, 4'b1101);
    chk("R6 full flag", 32'(st_stat_ovr), 1);
    mac_start = 1; step(); mac_start = 0;
    chk("R6 start refused", 32'(st_receiving), 0);
    mac_byte = 1; repeat (3) step(); mac_byte = 0;
    mac_end = 1; step(); mac_end = 0;
    chk("R6 no complete on drop", 32'(evt_rx_complete), 0);
    chk("R6 head unchanged", 32'(head_status), 32'({1'b0, 4'b1101, 11'd10}));
    discard();
    chk("R6 flag clears", 32'(st_stat_ovr), 0);
    send_pkt(99, 4'b0000);
    chk("R6 refilled", 32'(st_stat_ovr), 1);
    for (int i = 1; i < DEPTH; i++) begin
      chk("R5 order", 32'(head_status), 32'({1'b0, 4'b1101, 11'(10 + i)}));
      discard();
    end
    chk("R5 order last", 32'(head_status), 32'(99));
    discard();

    // R9: over-read on a queued packet
    send_pkt(3, 4'b0000);
    repeat (3) rd1();
    chk("R9 in-range reads", 32'(st_underrun), 0);
    rd1();
    chk("R9 underrun set", 32'(st_underrun), 1);
    chk("R9 fail pulse", 32'(evt_adapter_fail), 1);
    rd1();
    chk("R9 single pulse", 32'(evt_adapter_fail), 0);
    discard();
    chk("R9 sticky across discard", 32'(st_underrun), 1);
    rx_rst();
    chk("R13 underrun cleared", 32'(st_underrun), 0);
    rd1();
    chk("R9 empty read", 32'(st_underrun), 1);
    rx_rst();

    // R13: reset aborts in-progress packet and flushes queue
    send_pkt(4, 4'b0000);
    mac_start = 1; step(); mac_start = 0;
    mac_byte = 1; step(); mac_byte = 0;
    rx_rst();
    chk("R13 abort", {31'd0, st_receiving}, 0);
    chk("R13 flush", 32'(head_status), 32'h8000);

    // R11 early threshold
    early_thresh = 10; e0 = n_early; send_pkt(20, 0); step();
    chk("R11 one pulse", 32'(n_early - e0), 1);
    early_thresh = 0; e0 = n_early; send_pkt(20, 0); step();
    chk("R11 zero thresh", 32'(n_early - e0), 0);
    early_thresh = 25; e0 = n_early; send_pkt(20, 0); step();
    chk("R11 unreached", 32'(n_early - e0), 0);
    rx_rst();

    // R12 saturation
    send_pkt(2100, 0);
    chk("R12 saturate", 32'(head_status), 32'h07FF);
    rx_rst();

    // R7 sweep up and down with hysteresis model
    begin
      logic exp_o = 0;
      for (int k = 0; k < 512; k++) begin
        int lv = (k < 256) ? k : 511 - k;
        fifo_level = 8'(lv); step();
        if (lv >= CAP) exp_o = 1; else if (lv <= CAP - MARGIN) exp_o = 0;
        chk("R7 level sweep", 32'(st_rx_ovr), 32'(exp_o));
      end
    end
    fifo_level = 8'(CAP); step();
    mac_start = 1; step(); mac_start = 0;
    chk("R7 start refused", 32'(st_receiving), 0);
    rx_rst();
    chk("R13 keeps rx overrun", 32'(st_rx_ovr), 1);
    fifo_level = 8'(CAP - 2); step();
    chk("R7 hold in band", 32'(st_rx_ovr), 1);
    fifo_level = 8'(CAP - MARGIN); step();
    chk("R7 clears", 32'(st_rx_ovr), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule